// File: doc/BRIEF.md
# Base and Length Address Relocation Unit

This block turns addresses that a running program issues, all of them counted from zero, into physical addresses. It holds one relocation pair: a base that marks where the program's contiguous region starts in physical memory, and a length that marks how far the region extends. Each valid request has the base added to it. The result comes out one clock later, together with a fault flag that is raised when the relocated address lies past the end of the region.

Privileged software loads the pair through a small configuration port whenever a different program is scheduled. Writes that arrive without the privilege qualifier are dropped. Reset clears both registers and marks the unit unconfigured, so every request faults until software has written a value. A separate memory-enable output tells the memory system when a translated address may be used, and it stays low on any fault.

Top module: `reloc_xlate`

## Requirements
- R1: After reset the response outputs are all zero, and every request faults until at least one privileged configuration write has been accepted.
- R2: For a request that does not fault, rsp_paddr one cycle later equals base + req_vaddr.
- R3: rsp_valid equals req_valid delayed by exactly one clock.
- R4: A request faults when base + req_vaddr is strictly greater than base + length. A relocated address exactly equal to base + length does not fault.
- R5: Sums are formed one bit wider than ADDR_W. A request whose relocated address does not fit in ADDR_W bits faults and never wraps to a low address.
- R6: On a fault rsp_paddr is 0 and rsp_mem_en is 0. rsp_mem_en is 1 exactly when rsp_valid is 1 and rsp_fault is 0.
- R7: A configuration write with cfg_priv = 0 changes neither register and does not mark the unit configured.
- R8: cfg_sel = 0 selects the base register and cfg_sel = 1 selects the length register.
- R9: A request presented in the same cycle as a configuration write is translated with the register values from before that write.
- R10: A cycle without a request gives rsp_valid = 0, rsp_fault = 0 and rsp_paddr = 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 length |
| cfg_priv | input | 1 | Privileged-mode qualifier for configuration writes |
| cfg_wdata | input | ADDR_W | Value to write |
| req_valid | input | 1 | Request valid |
| req_vaddr | input | ADDR_W | Program-relative address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_paddr | output | ADDR_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Protection fault |
| rsp_mem_en | output | 1 | Translated address may be used for a memory access |

## Verification
The checker assumes that req_valid is low in the last cycle of internal reset. Without that, the one-cycle valid relation would compare against a request that the reset flop never captured. The bench holds every input at zero while reset is asserted and for several cycles after it is released. The window assertions also assume that base and length keep their values for the cycle in which a response is formed. The bench therefore changes them only through the configuration port, whose effect the model delays by one edge.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE = 1'b0,
    SEL_LEN  = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/reloc_rst_sync.sv
module reloc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/reloc_cfg_regs.sv
module reloc_cfg_regs
  import reloc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic              cfg_priv,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] len_q,
  output logic              cfg_ok_q
);
  logic              wr_ok;
  logic              base_en, len_en;
  logic [ADDR_W-1:0] base_d, len_d;
  logic              cfg_ok_d;
  cfg_sel_e          sel;

  always_comb begin
    sel      = cfg_sel_e'(cfg_sel);
    wr_ok    = cfg_we && cfg_priv;
    base_en  = wr_ok && (sel == SEL_BASE);
    len_en   = wr_ok && (sel == SEL_LEN);
    base_d   = cfg_wdata;
    len_d    = cfg_wdata;
    cfg_ok_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      len_q    <= '0;
      cfg_ok_q <= 1'b0;
    end else begin
      if (base_en) base_q   <= base_d;
      if (len_en)  len_q    <= len_d;
      if (wr_ok)   cfg_ok_q <= cfg_ok_d;
    end
  end
endmodule

// File: rtl/reloc_bound.sv
module reloc_bound #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] len,
  input  logic              cfg_ok,
  input  logic [ADDR_W-1:0] vaddr,
  output logic [ADDR_W-1:0] paddr,
  output logic              fault
);
  localparam int SUM_W = ADDR_W + 1;

  logic [SUM_W-1:0] reloc_sum;
  logic [SUM_W-1:0] limit_sum;
  logic             carry_out;
  logic             past_end;

  always_comb begin
    reloc_sum = {1'b0, base} + {1'b0, vaddr};
    limit_sum = {1'b0, base} + {1'b0, len};
    carry_out = reloc_sum[SUM_W-1];
    past_end  = reloc_sum > limit_sum;
    fault     = !cfg_ok || carry_out || past_end;
    paddr     = reloc_sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/reloc_resp.sv
module reloc_resp #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              fault,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_mem_en
);
  logic              valid_d, fault_d, mem_d;
  logic [ADDR_W-1:0] paddr_d;

  always_comb begin
    valid_d = req_valid;
    fault_d = req_valid && fault;
    mem_d   = req_valid && !fault;
    paddr_d = mem_d ? paddr : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_mem_en <= 1'b0;
      rsp_paddr  <= '0;
    end else begin
      rsp_valid  <= valid_d;
      rsp_fault  <= fault_d;
      rsp_mem_en <= mem_d;
      rsp_paddr  <= paddr_d;
    end
  end
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic              cfg_priv,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              rsp_mem_en
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q, len_q;
  logic              cfg_ok_q;
  logic [ADDR_W-1:0] xl_paddr;
  logic              xl_fault;

  reloc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  reloc_cfg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_priv  (cfg_priv),
    .cfg_wdata (cfg_wdata),
    .base_q    (base_q),
    .len_q     (len_q),
    .cfg_ok_q  (cfg_ok_q)
  );

  reloc_bound #(.ADDR_W(ADDR_W)) u_bound (
    .base   (base_q),
    .len    (len_q),
    .cfg_ok (cfg_ok_q),
    .vaddr  (req_vaddr),
    .paddr  (xl_paddr),
    .fault  (xl_fault)
  );

  reloc_resp #(.ADDR_W(ADDR_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .paddr      (xl_paddr),
    .fault      (xl_fault),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault),
    .rsp_mem_en (rsp_mem_en)
  );
endmodule

// File: rtl/reloc_xlate_chk.sv
module reloc_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              cfg_priv,
  input logic              cfg_ok_q,
  input logic [ADDR_W-1:0] base_q,
  input logic [ADDR_W-1:0] len_q,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              rsp_mem_en
);
  p_valid_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  p_fault_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_mem_en));

  p_fault_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault || rsp_mem_en) |-> rsp_valid);

  p_unpriv_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> ($stable(base_q) && $stable(len_q) && $stable(cfg_ok_q)));

  p_unconfig_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cfg_ok_q) |=> rsp_fault);

  p_above_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mem_en |-> rsp_paddr >= $past(base_q));

  p_within_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mem_en |-> ({1'b0, rsp_paddr} <= ({1'b0, $past(base_q)} + {1'b0, $past(len_q)})));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_paddr == '0 && !rsp_fault));
endmodule

bind reloc_xlate reloc_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_priv   (cfg_priv),
  .cfg_ok_q   (cfg_ok_q),
  .base_q     (base_q),
  .len_q      (len_q),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_paddr  (rsp_paddr),
  .rsp_fault  (rsp_fault),
  .rsp_mem_en (rsp_mem_en)
);

// File: tb/test_reloc_xlate.sv
module test_reloc_xlate;
  localparam int W = 32;
  localparam longint TOP = 64'h0000_0000_FFFF_FFFF;

  logic         clk;
  logic         rst_n;
  logic         cfg_we, cfg_sel, cfg_priv;
  logic [W-1:0] cfg_wdata;
  logic         req_valid;
  logic [W-1:0] req_vaddr;
  logic         rsp_valid, rsp_fault, rsp_mem_en;
  logic [W-1:0] rsp_paddr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  reloc_xlate #(.ADDR_W(W)) i_reloc_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_mem_en(rsp_mem_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference model
  bit     chk_on = 0;
  bit     exp_ready = 0;
  longint m_base = 0, m_len = 0;
  bit     m_cfg = 0;
  bit     e_valid, e_fault, e_mem;
  longint e_paddr;
  string  cur_tag = "R1";
  string  e_tag;

  always @(posedge clk) begin
    if (chk_on) begin
      longint phys, lim;
      bit flt;
      phys = m_base + longint'(req_vaddr);
      lim  = m_base + m_len;
      flt  = !m_cfg || (phys > TOP) || (phys > lim);
      e_valid = req_valid;
      e_fault = req_valid && flt;
      e_mem   = req_valid && !flt;
      e_paddr = e_mem ? phys : 0;
      e_tag   = cur_tag;
      exp_ready = 1;
      if (cfg_we && cfg_priv) begin
        if (cfg_sel) m_len = longint'(cfg_wdata);
        else         m_base = longint'(cfg_wdata);
        m_cfg = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && exp_ready && !done) begin
      compared++;
      if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_mem_en !== e_mem ||
          longint'(rsp_paddr) !== e_paddr) begin
        mismatched++;
        $display("FAIL %s: got v=%0b f=%0b m=%0b pa=%h, expected v=%0b f=%0b m=%0b pa=%h",
                 e_tag, rsp_valid, rsp_fault, rsp_mem_en, rsp_paddr,
                 e_valid, e_fault, e_mem, e_paddr[W-1:0]);
      end
    end
  end

  task automatic step(input bit we, input bit sel, input bit priv, input logic [W-1:0] wd,
                      input bit rv, input logic [W-1:0] va);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_priv = priv; cfg_wdata = wd;
    req_valid = rv; req_vaddr = va;
    @(posedge clk);
  endtask

  task automatic req(input logic [W-1:0] va);
    step(0, 0, 0, '0, 1, va);
  endtask

  task automatic wr(input bit sel, input bit priv, input logic [W-1:0] wd);
    step(1, sel, priv, wd, 0, '0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cfg_we = 0; cfg_sel = 0; cfg_priv = 0; cfg_wdata = '0;
    req_valid = 0; req_vaddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs cleared while reset is held
    compared++;
    if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_mem_en !== 0 || rsp_paddr !== '0) begin
      mismatched++;
      $display("FAIL R1: got v=%0b f=%0b m=%0b pa=%h, expected all zero",
               rsp_valid, rsp_fault, rsp_mem_en, rsp_paddr);
    end
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk_on = 1;

    // R1: unconfigured unit faults everything, even address 0 against a zero limit
    cur_tag = "R1";
    req(32'h0); req(32'h10);
    // R7: unprivileged writes do not configure
    cur_tag = "R7";
    wr(0, 0, 32'h0000_4000); wr(1, 0, 32'h0000_1000);
    req(32'h0); req(32'h20);
    // R8: base then length through the select
    cur_tag = "R8";
    wr(0, 1, 32'h0000_1000); wr(1, 1, 32'h0000_0100);
    req(32'h0);
    // R2: translation in range
    cur_tag = "R2";
    req(32'h80); req(32'h4);
    // R4: exact end passes, one beyond faults
    cur_tag = "R4";
    req(32'h100); req(32'h101); req(32'hFFFF);
    // R7: unprivileged write leaves mapping alone
    cur_tag = "R7";
    wr(0, 0, 32'h0008_0000); req(32'h40);
    wr(1, 0, 32'h0000_0000); req(32'h100);
    // R10: idle cycles
    cur_tag = "R10";
    step(0, 0, 0, '0, 0, 32'h55); step(0, 0, 0, '0, 0, 32'h0);
    // R9: request with a concurrent base write uses the old base
    cur_tag = "R9";
    step(1, 0, 1, 32'h0002_0000, 1, 32'h10);
    req(32'h10);
    // R5: wrap-around near the top of the address space
    cur_tag = "R5";
    wr(0, 1, 32'hFFFF_FF00); wr(1, 1, 32'h0000_0200);
    req(32'hFF); req(32'h100); req(32'hFFFF_FFFF);
    // R6: faults give zero address and no memory enable
    cur_tag = "R6";
    wr(0, 1, 32'h0000_8000); wr(1, 1, 32'h0000_0000);
    req(32'h0); req(32'h1);
    // R3: back-to-back and gapped requests
    cur_tag = "R3";
    req(32'h0); step(0, 0, 0, '0, 0, '0); req(32'h0); req(32'h0);

    // R2: mixed random traffic
    cur_tag = "R2";
    for (int i = 0; i < 400; i++) begin
      bit we = ($urandom_range(0, 7) == 0);
      logic [W-1:0] wd;
      logic [W-1:0] va;
      wd = ($urandom_range(0, 3) == 0) ? $urandom : $urandom_range(0, 32'h0001_0000);
      va = ($urandom_range(0, 1) == 0) ? W'(m_len) + W'($urandom_range(0, 4)) - W'(2)
                                       : $urandom_range(0, 32'h0000_2000);
      step(we, $urandom_range(0, 1), $urandom_range(0, 1), wd,
           $urandom_range(0, 3) != 0, va);
    end
    step(0, 0, 0, '0, 0, '0);
    step(0, 0, 0, '0, 0, '0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule